// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether an incoming Ethernet frame is kept or dropped, judging only by its 48-bit destination address and its length. The receive path presents the six destination bytes one at a time, in the order they come off the wire. The first byte is marked with a start flag. The frame length, known from the receive path, is held on its own input while the sixth byte is presented.

One clock after the sixth byte, the block raises a one-cycle valid strobe together with an accept flag. The filter can accept a frame on four grounds:

- a match with programmable station address 0;
- a match with programmable station address 1;
- the all-ones broadcast address;
- a single bit of a 64-entry hash table. The bit is picked by XOR-folding the address into a 6-bit index.

Configuration arrives as 32-bit word writes through a small select-coded write port. Every configuration register clears to zero on reset, so the filter drops every frame until it is set up.

Top module: `rx_addr_filter`

## Requirements
- R1: Station address 0 is written as two words: select code 0 is the low word, holding byte 0 in bits 7:0 through byte 3 in bits 31:24. Select code 1 is the high word, holding byte 4 in bits 7:0 and byte 5 in bits 15:8. When mode bit 0 is set, a destination equal to that address is accepted.
- R2: Station address 1 uses select codes 2 (low word) and 3 (high word), with the same packing as R1. It is matched only while mode bit 1 is set.
- R3: While mode bit 3 is set, the destination FF:FF:FF:FF:FF:FF is accepted.
- R4: The hash index is the XOR of the eight consecutive 6-bit groups of the address. The 48-bit address is ordered with byte 0 in bits 7:0 and byte 5 in bits 47:40, and group k is bits 6k+5..6k. So the first group is byte0[5:0] and the second is {byte1[3:0], byte0[7:6]}.
- R5: The hash table is written with select code 4 (entries 0..31, bit n = entry n) and select code 5 (entries 32..63, bit n = entry n+32). An index of 32 or more tests the high word.
- R6: The hash test applies only to group addresses, meaning bit 0 of byte 0 is 1. When mode bit 2 is set, it applies to every address.
- R7: A frame whose length is below 12 bytes is dropped, whatever the address.
- R8: The decision strobe is high for exactly one cycle, one clock after the sixth address byte is presented. Bytes after the sixth, and bytes that arrive before any start-marked byte, produce no strobe.
- R9: After reset, every configuration register is zero and every frame is dropped.
- R10: The mode register is select code 6, and only its bits 3:0 are used. A frame is accepted when any enabled check from R1, R2, R3 or R6 matches and R7 does not reject it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| byte_valid | input | 1 | An address byte is present |
| byte_first | input | 1 | Marks the first destination byte of a frame |
| byte_data | input | 8 | Destination address byte, wire order |
| frame_len | input | 16 | Frame length in bytes, sampled with the sixth byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Accept (1) or drop (0), qualified by dec_valid |

## Verification
A byte stored in the wrong slot, or a byte counter that is off by one, changes the assembled address. The result is a wrong accept bit on the very strobe that closes the frame, or a strobe that comes one byte early, one byte late or not at all. An error in the fold or in the choice of table half shows up only for addresses whose index lands on a programmed bit. For that reason the bench checks both halves with directed addresses and then sweeps random tables. A configuration register that is wrong after reset shows up on the first frame, as an accept that should have been a drop.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int MAC_W      = 8 * ADDR_BYTES;
  localparam int HASH_W     = 6;
  localparam int TBL_SIZE   = 1 << HASH_W;

  localparam logic [2:0] SEL_ST_BASE  = 3'd0;
  localparam logic [2:0] SEL_TBL_BASE = 3'd4;
  localparam logic [2:0] SEL_MODE     = 3'd6;

  typedef struct packed {
    logic bcast_en;
    logic hash_indiv;
    logic st1_en;
    logic st0_en;
  } mode_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = MAC_W,
  parameter int TBL_BITS = TBL_SIZE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] st0,
  output logic [ADDR_W-1:0] st1,
  output logic [TBL_BITS-1:0] tbl,
  output mode_t             mode
);
  localparam int HI_W      = ADDR_W - DATA_W;
  localparam int TBL_WORDS = TBL_BITS / DATA_W;
  localparam int N_ST      = 2;

  logic [ADDR_W-1:0] st_arr [N_ST];

  for (genvar g = 0; g < N_ST; g++) begin : g_station
    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we && sel == SEL_ST_BASE + 3'(2 * g)) begin
        lo_q <= wdata;
      end else if (we && sel == SEL_ST_BASE + 3'(2 * g + 1)) begin
        hi_q <= wdata[HI_W-1:0];
      end
    end
    assign st_arr[g] = {hi_q, lo_q};
  end

  assign st0 = st_arr[0];
  assign st1 = st_arr[1];

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_table
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[w*DATA_W +: DATA_W] <= '0;
      end else if (we && sel == SEL_TBL_BASE + 3'(w)) begin
        tbl[w*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
    end else if (we && sel == SEL_MODE) begin
      mode <= mode_t'(wdata[3:0]);
    end
  end

  AST_CFG_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == '0 && tbl == '0 && st0 == '0 && st1 == '0)); // R9

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(mode)); // R10
endmodule

// File: rtl/rxf_addr_collect.sv
module rxf_addr_collect #(
  parameter int NBYTES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_valid,
  input  logic                byte_first,
  input  logic [7:0]          byte_data,
  output logic                addr_done,
  output logic [8*NBYTES-1:0] addr
);
  localparam int CNT_W = $clog2(NBYTES + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] idx;
  logic             take;
  logic [7:0]       held [NBYTES-1];

  assign idx       = byte_first ? '0 : cnt;
  assign take      = byte_valid && (byte_first || cnt < CNT_W'(NBYTES));
  assign addr_done = take && (idx == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(NBYTES);
    end else if (take) begin
      cnt <= idx + 1'b1;
    end
  end

  for (genvar b = 0; b < NBYTES - 1; b++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        held[b] <= '0;
      end else if (take && idx == CNT_W'(b)) begin
        held[b] <= byte_data;
      end
    end
    assign addr[8*b +: 8] = held[b];
  end
  assign addr[8*(NBYTES-1) +: 8] = byte_data;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(NBYTES)); // R8

  AST_CNT_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(NBYTES) && !byte_first) |=> cnt == CNT_W'(NBYTES)); // R8
endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
  parameter int IN_W  = 48,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  addr,
  output logic [OUT_W-1:0] idx
);
  localparam int NGRP = IN_W / OUT_W;

  logic [OUT_W-1:0] part [NGRP+1];
  assign part[0] = '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_fold
    assign part[g+1] = part[g] ^ addr[g*OUT_W +: OUT_W];
  end

  assign idx = part[NGRP];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              byte_valid,
  input  logic              byte_first,
  input  logic [7:0]        byte_data,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [MAC_W-1:0]    st0, st1, addr;
  logic [TBL_SIZE-1:0] tbl;
  mode_t               mode;
  logic                addr_done;
  logic [HASH_W-1:0]   hidx;
  logic hit0, hit1, hitb, hith, len_ok, accept_now;

  rxf_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(MAC_W), .TBL_BITS(TBL_SIZE)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .st0(st0), .st1(st1), .tbl(tbl), .mode(mode)
  );

  rxf_addr_collect #(.NBYTES(ADDR_BYTES)) col_i (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .addr_done(addr_done), .addr(addr)
  );

  rxf_hash_fold #(.IN_W(MAC_W), .OUT_W(HASH_W)) fold_i (
    .addr(addr), .idx(hidx)
  );

  assign hit0       = mode.st0_en && (addr == st0);
  assign hit1       = mode.st1_en && (addr == st1);
  assign hitb       = mode.bcast_en && (&addr);
  assign hith       = (addr[0] || mode.hash_indiv) && tbl[hidx];
  assign len_ok     = frame_len >= LEN_W'(MIN_LEN);
  assign accept_now = len_ok && (hit0 || hit1 || hitb || hith);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= addr_done;
      dec_accept <= addr_done && accept_now;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid); // R8
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid); // R8
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(byte_valid)); // R8
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(frame_len) < LEN_W'(MIN_LEN)) |-> !dec_accept); // R7
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(mode == '0 && tbl == '0)) |-> !dec_accept); // R9
  AST_BCAST_TAKE: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past((&addr) && mode.bcast_en && frame_len >= LEN_W'(MIN_LEN)))
      |-> dec_accept); // R3
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        byte_valid = 1'b0;
  logic        byte_first = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [15:0] frame_len = '0;
  logic        dec_valid, dec_accept;

  int total = 0;
  int bad = 0;
  logic [47:0] s0 = '0, s1 = '0;
  logic [63:0] tb_tbl = '0;
  logic [3:0]  tb_mode = '0;
  logic        got_v, got_a;

  always #10 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
    .frame_len(frame_len), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic logic [5:0] m_idx(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int j = 0; j < 6; j++)
      for (int k = 0; k < 8; k++)
        r[j] = r[j] ^ a[6*k + j];
    return r;
  endfunction

  function automatic logic m_acc(input logic [47:0] a, input logic [15:0] len);
    logic hit;
    hit = (tb_mode[0] && a == s0) || (tb_mode[1] && a == s1) ||
          (tb_mode[3] && a == 48'hFFFF_FFFF_FFFF) ||
          ((a[0] || tb_mode[2]) && tb_tbl[m_idx(a)]);
    return hit && (len >= 16'd12);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_st(input int which, input logic [47:0] a);
    wr(3'(2 * which), a[31:0]);
    wr(3'(2 * which + 1), {16'h0, a[47:32]});
    if (which == 0) s0 = a; else s1 = a;
  endtask

  task automatic set_tbl(input logic [63:0] t);
    wr(3'd4, t[31:0]);
    wr(3'd5, t[63:32]);
    tb_tbl = t;
  endtask

  task automatic set_mode(input logic [3:0] m);
    wr(3'd6, {28'hABCDEF0, m});
    tb_mode = m;
  endtask

  task automatic send(input logic [47:0] a, input logic [15:0] len);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_first = (i == 0); byte_data = a[8*i +: 8]; frame_len = len;
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_first = 1'b0;
    got_v = dec_valid; got_a = dec_accept;
  endtask

  task automatic frame(input logic [47:0] a, input logic [15:0] len, input string req);
    logic e;
    e = m_acc(a, len);
    send(a, len);
    chk(got_v == 1'b1, "R8 strobe", 64'(got_v), 64'd1);
    chk(got_a == e, req, 64'(got_a), 64'(e));
  endtask

  task automatic stray_byte(input string req);
    @(negedge clk);
    byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'hFF;
    @(negedge clk);
    byte_valid = 1'b0;
    chk(dec_valid == 1'b0, req, 64'(dec_valid), 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [15:0] ln;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R9 reset outputs", {dec_valid, dec_accept}, 0);
    stray_byte("R8 byte before start ignored");
    frame(48'hFFFF_FFFF_FFFF, 16'd64, "R9 broadcast dropped when unconfigured");
    frame(48'h0000_0000_0000, 16'd64, "R9 zero address dropped when unconfigured");

    set_st(0, 48'hA1B2_C3D4_E5F6);
    set_mode(4'b0001);
    frame(48'hA1B2_C3D4_E5F6, 16'd64, "R1 station 0 match");
    chk(got_a == 1'b1, "R1 station 0 accept", 64'(got_a), 64'd1);
    frame(48'hA1B2_C3D4_E5F4, 16'd64, "R1 byte 0 differs");
    frame(48'hA0B2_C3D4_E5F6, 16'd64, "R1 byte 5 differs");
    stray_byte("R8 seventh byte ignored");
    frame(48'hA1B2_C3D4_E5F6, 16'd11, "R7 length 11 dropped");
    chk(got_a == 1'b0, "R7 short drop", 64'(got_a), 64'd0);
    frame(48'hA1B2_C3D4_E5F6, 16'd12, "R7 length 12 accepted");

    set_st(1, 48'h0246_8ACE_1357 & 48'hFFFF_FFFF_FFFE);
    set_mode(4'b0010);
    frame(s1, 16'd64, "R2 station 1 match");
    frame(s0, 16'd64, "R2 station 0 disabled");
    chk(got_a == 1'b0, "R10 disabled station drop", 64'(got_a), 64'd0);

    set_mode(4'b1000);
    frame(48'hFFFF_FFFF_FFFF, 16'd64, "R3 broadcast enabled");
    set_mode(4'b0000);
    frame(48'hFFFF_FFFF_FFFF, 16'd64, "R3 broadcast disabled");

    chk(m_idx(48'h0000_0000_0101) == 6'd5, "R4 model fold", 64'(m_idx(48'h0101)), 64'd5);
    set_tbl(64'h0000_0000_0000_0020);
    frame(48'h0000_0000_0101, 16'd64, "R4 fold across bytes 0 and 1, index 5");
    set_tbl(64'h0000_0002_0000_0000);
    frame(48'h8000_0000_0001, 16'd64, "R4 fold with byte 5, index 33");
    frame(48'h0000_0000_0021, 16'd64, "R5 high half index 33");
    set_tbl(64'h0000_0000_0000_0002);
    frame(48'h0000_0000_0021, 16'd64, "R5 low bit does not serve index 33");
    frame(48'h0000_0000_0001, 16'd64, "R5 low half index 1");

    set_tbl(64'h0000_0000_0000_0004);
    frame(48'h0000_0000_0002, 16'd64, "R6 individual address skips hash");
    set_mode(4'b0100);
    frame(48'h0000_0000_0002, 16'd64, "R6 individual hash mode");
    frame(48'h0000_0000_0002, 16'd8, "R7 short frame with hash hit");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0) set_tbl({$urandom, $urandom});
      if ($urandom_range(0, 9) == 0) set_mode(4'($urandom));
      if ($urandom_range(0, 29) == 0) set_st(int'($urandom_range(0, 1)), {16'($urandom), $urandom});
      case ($urandom_range(0, 4))
        0: a = s0;
        1: a = s1;
        2: a = 48'hFFFF_FFFF_FFFF;
        default: a = {16'($urandom), $urandom};
      endcase
      ln = ($urandom_range(0, 5) == 0) ? 16'($urandom_range(0, 13)) : 16'($urandom_range(12, 1518));
      frame(a, ln, "R10 random frame decision");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule